// File: doc/BRIEF.md
# Type B Tag Response Frame Encoder

This block turns a buffer of response bytes into the serial bit stream a Type B proximity tag sends back to a reader. A controller places the bytes, trailing CRC included, in a buffer, presents the byte count and pulses `start`. The encoder fetches the bytes one at a time through a read-address/data port. It emits one bit per accepted transfer: a run of ones that lets the reader lock its phase, a start-of-frame mark, each byte as a ten-bit character, and an end-of-frame mark. It adds no CRC of its own.

The bit stream is a valid/ready interface. `bit_vld` stays high for the whole frame, and a bit moves on every clock edge where `bit_vld` and `bit_rdy` are both high. The downstream modulator drives `bit_rdy` once per bit period, which paces the encoder. While `bit_rdy` is low the encoder holds `bit_out` and the frame position, so a consumer may stall for any length of time. When the last bit has been taken, `done` pulses and `enc_len` gives the frame length in bits.

Top module: `tbe_frame_enc`

## Requirements
- R1: After reset `bit_vld` and `done` are low and `enc_len` is 0.
- R2: A frame opens with 20 transferred bits of value 1, and `bit_vld` rises in the cycle after `start` is accepted.
- R3: The preamble is followed by a start-of-frame mark of 10 zero bits and then 2 one bits.
- R4: Each byte is sent as ten bits: a 0 start bit, the 8 data bits least significant bit first, and a 1 stop bit.
- R5: After the last character comes an end-of-frame mark of 10 zero bits and then 2 one bits.
- R6: A byte count of 0 gives the preamble, the start-of-frame mark and the end-of-frame mark, with no characters between them (44 bits).
- R7: `done` is high for exactly one cycle, the cycle after the final end-of-frame bit is transferred. `bit_vld` is low in that cycle.
- R8: When `done` is high, `enc_len` equals the number of bits transferred in the frame, 44 + 10 x byte count.
- R9: A `start` pulse while a frame is in progress is ignored. The frame in flight goes on unchanged with its original byte count.
- R10: While `bit_vld` is high and `bit_rdy` is low, the next cycle keeps `bit_vld` high and `bit_out` unchanged.
- R11: While a character is being sent, `rd_addr` holds the index of its byte, counting from 0 up to byte count - 1. `rd_data` is read combinationally at that address and must stay stable while `rd_addr` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame; taken only when idle |
| byte_count | input | 8 | Number of buffer bytes to send, sampled at start |
| rd_addr | output | 8 | Buffer read address |
| rd_data | input | 8 | Buffer byte at `rd_addr` |
| bit_out | output | 1 | Current frame bit |
| bit_vld | output | 1 | A frame bit is on offer |
| bit_rdy | input | 1 | Consumer takes the bit on this edge |
| done | output | 1 | One-cycle pulse at the end of a frame |
| enc_len | output | 13 | Frame length in bits, updated at `done` |

## Verification
A wrong phase or segment counter shows up as a bit of the wrong value at the exact transfer where the segment boundary moved, so it is caught within one bit period of the fault. A slip in the byte index or the character shifter corrupts the first data bit after it, and also shows as a wrong `rd_addr` during that character. A wrong length counter or end-of-frame decision surfaces only at the end of the frame, as a misplaced `done` or a wrong `enc_len`. Stalls and a mid-frame `start` are mixed into the sweep so that hold and ignore faults also show on the stream.

// File: rtl/tbe_pkg.sv
package tbe_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_SOFZ,
    PH_SOFO,
    PH_CHAR,
    PH_EOFZ,
    PH_EOFO
  } tbe_phase_e;

  localparam int CHAR_BITS = 10;
endpackage

// File: rtl/tbe_seq.sv
module tbe_seq
  import tbe_pkg::*;
#(
  parameter int PRE_LEN  = 20,
  parameter int ZERO_LEN = 10,
  parameter int ONE_LEN  = 2,
  parameter int CNT_W    = 8,
  parameter int SEG_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] nbytes,
  input  logic             xfer,
  output tbe_phase_e       phase,
  output logic [SEG_W-1:0] seg_cnt,
  output logic [CNT_W-1:0] byte_idx,
  output logic [CNT_W-1:0] nbytes_q,
  output logic             frame_last
);
  logic [SEG_W-1:0] seg_len;
  logic             seg_end;
  logic             last_byte;
  tbe_phase_e       nxt_phase;

  always_comb begin
    case (phase)
      PH_PRE:           seg_len = SEG_W'(PRE_LEN);
      PH_SOFZ, PH_EOFZ: seg_len = SEG_W'(ZERO_LEN);
      PH_SOFO, PH_EOFO: seg_len = SEG_W'(ONE_LEN);
      PH_CHAR:          seg_len = SEG_W'(CHAR_BITS);
      default:          seg_len = SEG_W'(1);
    endcase
  end

  assign seg_end    = (seg_cnt == seg_len - 1'b1);
  assign last_byte  = ({1'b0, byte_idx} + 1'b1) == {1'b0, nbytes_q};
  assign frame_last = (phase == PH_EOFO) && seg_end;

  always_comb begin
    case (phase)
      PH_PRE:  nxt_phase = PH_SOFZ;
      PH_SOFZ: nxt_phase = PH_SOFO;
      PH_SOFO: nxt_phase = (nbytes_q == '0) ? PH_EOFZ : PH_CHAR;
      PH_CHAR: nxt_phase = last_byte ? PH_EOFZ : PH_CHAR;
      PH_EOFZ: nxt_phase = PH_EOFO;
      default: nxt_phase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      seg_cnt  <= '0;
      byte_idx <= '0;
      nbytes_q <= '0;
    end else if (phase == PH_IDLE) begin
      if (start) begin
        phase    <= PH_PRE;
        seg_cnt  <= '0;
        byte_idx <= '0;
        nbytes_q <= nbytes;
      end
    end else if (xfer) begin
      if (!seg_end) begin
        seg_cnt <= seg_cnt + 1'b1;
      end else begin
        seg_cnt <= '0;
        phase   <= nxt_phase;
        if (phase == PH_CHAR && !last_byte) byte_idx <= byte_idx + 1'b1;
      end
    end
  end

  // R11: the byte index never runs past the latched count
  assert_addr_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CHAR) |-> (byte_idx < nbytes_q));

  // R9: the latched count cannot change while a frame is running
  assert_count_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |=> $stable(nbytes_q));
endmodule

// File: rtl/tbe_char.sv
module tbe_char #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] din,
  output logic              lsb
);
  logic [DATA_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n)     shreg <= '0;
    else if (load)  shreg <= din;
    else if (shift) shreg <= {1'b0, shreg[DATA_W-1:1]};
  end

  assign lsb = shreg[0];

  // R4: a character is loaded at its start bit, never while data bits shift
  assert_load_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift));
endmodule

// File: rtl/tbe_lenctr.sv
module tbe_lenctr #(
  parameter int LEN_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  input  logic             fin,
  output logic [LEN_W-1:0] enc_len,
  output logic             done
);
  logic [LEN_W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      enc_len <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (clear) begin
        count <= '0;
      end else if (inc) begin
        count <= count + 1'b1;
        if (fin) begin
          enc_len <= count + 1'b1;
          done    <= 1'b1;
        end
      end
    end
  end

  // R7: done never lasts two cycles
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/tbe_frame_enc.sv
module tbe_frame_enc
  import tbe_pkg::*;
#(
  parameter int PRE_LEN  = 20,
  parameter int ZERO_LEN = 10,
  parameter int ONE_LEN  = 2,
  parameter int CNT_W    = 8,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  byte_count,
  output logic [CNT_W-1:0]  rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              bit_out,
  output logic              bit_vld,
  input  logic              bit_rdy,
  output logic              done,
  output logic [CNT_W+4:0]  enc_len
);
  localparam int FIXED_LEN = PRE_LEN + 2 * (ZERO_LEN + ONE_LEN);
  localparam int SEG_MAX   = (PRE_LEN > ZERO_LEN) ?
                             ((PRE_LEN > CHAR_BITS) ? PRE_LEN : CHAR_BITS) :
                             ((ZERO_LEN > CHAR_BITS) ? ZERO_LEN : CHAR_BITS);
  localparam int SEG_W     = $clog2(SEG_MAX + 1);
  localparam int LEN_W     = CNT_W + 5;

  tbe_phase_e       phase;
  logic [SEG_W-1:0] seg_cnt;
  logic [CNT_W-1:0] byte_idx;
  logic [CNT_W-1:0] nbytes_q;
  logic             frame_last;
  logic             xfer;
  logic             accept;
  logic             in_char;
  logic             char_load;
  logic             char_shift;
  logic             data_lsb;

  assign bit_vld    = (phase != PH_IDLE);
  assign xfer       = bit_vld && bit_rdy;
  assign accept     = start && (phase == PH_IDLE);
  assign in_char    = (phase == PH_CHAR);
  assign char_load  = xfer && in_char && (seg_cnt == '0);
  assign char_shift = xfer && in_char && (seg_cnt != '0) &&
                      (seg_cnt != SEG_W'(CHAR_BITS - 1));
  assign rd_addr    = byte_idx;

  tbe_seq #(
    .PRE_LEN(PRE_LEN), .ZERO_LEN(ZERO_LEN), .ONE_LEN(ONE_LEN),
    .CNT_W(CNT_W), .SEG_W(SEG_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .nbytes(byte_count),
    .xfer(xfer), .phase(phase), .seg_cnt(seg_cnt), .byte_idx(byte_idx),
    .nbytes_q(nbytes_q), .frame_last(frame_last)
  );

  tbe_char #(.DATA_W(DATA_W)) u_char (
    .clk(clk), .rst_n(rst_n), .load(char_load), .shift(char_shift),
    .din(rd_data), .lsb(data_lsb)
  );

  tbe_lenctr #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n), .clear(accept), .inc(xfer),
    .fin(frame_last), .enc_len(enc_len), .done(done)
  );

  always_comb begin
    case (phase)
      PH_PRE, PH_SOFO, PH_EOFO: bit_out = 1'b1;
      PH_CHAR: begin
        if (seg_cnt == '0)                          bit_out = 1'b0;
        else if (seg_cnt == SEG_W'(CHAR_BITS - 1))  bit_out = 1'b1;
        else                                        bit_out = data_lsb;
      end
      default: bit_out = 1'b0;
    endcase
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && !bit_rdy) |=> (bit_vld && $stable(bit_out)));

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bit_vld);

  assert_len_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (enc_len == LEN_W'(FIXED_LEN) + LEN_W'(CHAR_BITS) * LEN_W'(nbytes_q)));

  assert_pre_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bit_vld) |-> bit_out);
endmodule

// File: tb/sim_tbe_frame_enc.sv
module sim_tbe_frame_enc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  byte_count = '0;
  logic [7:0]  rd_addr;
  logic [7:0]  rd_data;
  logic        bit_out;
  logic        bit_vld;
  logic        bit_rdy = 1'b0;
  logic        done;
  logic [12:0] enc_len;

  int checks = 0;
  int errors = 0;
  int nb_cur = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  tbe_frame_enc u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .rd_addr(rd_addr), .rd_data(rd_data), .bit_out(bit_out),
    .bit_vld(bit_vld), .bit_rdy(bit_rdy), .done(done), .enc_len(enc_len)
  );

  function automatic logic [7:0] pat(int n, int i);
    return 8'((i * 37 + n * 11 + 90) ^ (i << 3));
  endfunction

  assign rd_data = pat(nb_cur, int'(rd_addr));

  function automatic logic expbit(int n, int k);
    int c, p, e;
    logic [7:0] b;
    if (k < 20) return 1'b1;
    if (k < 30) return 1'b0;
    if (k < 32) return 1'b1;
    if (k < 32 + 10 * n) begin
      c = (k - 32) / 10;
      p = (k - 32) % 10;
      b = pat(n, c);
      if (p == 0) return 1'b0;
      if (p == 9) return 1'b1;
      return b[p-1];
    end
    e = k - 32 - 10 * n;
    return (e < 10) ? 1'b0 : 1'b1;
  endfunction

  function automatic string region(int n, int k);
    if (k < 20) return "R2";
    if (k < 32) return "R3";
    if (k < 32 + 10 * n) return "R4";
    return (n == 0) ? "R6" : "R5";
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_frame(int n, int mode, bit inject);
    int k = 0;
    int total = 44 + 10 * n;
    bit prev_hold = 0;
    logic prevbit = 1'b0;
    logic rdy;
    @(negedge clk);
    nb_cur = n;
    byte_count = 8'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (k < total) begin
      if (prev_hold) chk(bit_vld && (bit_out == prevbit), "R10", int'(bit_out), int'(prevbit));
      if (!bit_vld) chk(1'b0, "R2", 0, 1);
      if (done) chk(1'b0, "R7", 1, 0);
      rdy = (mode == 0) ? 1'b1 : (((cyc * 7 + 3) % 5) != 0 && (cyc % 23) > 2);
      cyc++;
      bit_rdy = rdy;
      if (inject && k == 5) begin
        start = 1'b1;
        byte_count = 8'(n + 4);
      end else begin
        start = 1'b0;
      end
      if (bit_vld && rdy) begin
        chk(bit_out == expbit(n, k), inject ? "R9" : region(n, k),
            int'(bit_out), int'(expbit(n, k)));
        if (k >= 32 && k < 32 + 10 * n)
          chk(int'(rd_addr) == (k - 32) / 10, "R11", int'(rd_addr), (k - 32) / 10);
        k++;
      end
      prev_hold = bit_vld && !rdy;
      prevbit = bit_out;
      @(negedge clk);
    end
    start = 1'b0;
    bit_rdy = 1'b0;
    chk(done == 1'b1, "R7", int'(done), 1);
    chk(bit_vld == 1'b0, "R7", int'(bit_vld), 0);
    chk(int'(enc_len) == total, (n == 0) ? "R6" : "R8", int'(enc_len), total);
    @(negedge clk);
    chk(done == 1'b0, "R7", int'(done), 0);
    chk(bit_vld == 1'b0, "R9", int'(bit_vld), 0);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(bit_vld == 1'b0, "R1", int'(bit_vld), 0);
    chk(done == 1'b0, "R1", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bit_vld == 1'b0, "R1", int'(bit_vld), 0);
    chk(int'(enc_len) == 0, "R1", int'(enc_len), 0);
    for (int m = 0; m < 2; m++) begin
      run_frame(0, m, 1'b0);
      run_frame(1, m, 1'b0);
      run_frame(2, m, 1'b0);
      run_frame(3, m, 1'b1);
      run_frame(5, m, 1'b0);
      run_frame(16, m, 1'b0);
      run_frame(255, m, 1'b0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule